// File: doc/BRIEF.md
# Hub End-of-Frame Babble Guard

This block sits beside a hub's repeater and watches the hub's own frame timer. That timer counts down once per full-speed bit time and reaches zero near the end of every frame. While the timer is locked to the host's start-of-frame packets, the guard marks two late points in the frame. At the first, earlier point it asks the upstream port to send a four-bit-time end-of-packet. This closes any upstream path before the upstream hub can treat this hub as a babbler. At the second, later point it issues a one-cycle disable strobe for every downstream port that still holds upstream connectivity.

Both points are given as distances in bit times before the end of the frame. A separate offset covers the delay between the start of a frame and the moment the timer reaches zero. Elaboration checks enforce three rules. The gap between the points must leave room for the end-of-packet plus nine bit times of accumulated skew. The later point must also stay more than that skew away from the frame end. A build-time option lets the end-of-packet also be sent when no port holds the path. A third output, the connectivity inhibit, blocks every downstream port from connecting. It is raised at reset and again on any resume, and it drops only after the timer shows a fresh transition into lock.

Top module: `hub_eof_guard`

## Requirements
- R1: While `locked` is low at a sampling edge, that edge produces no point mark, starts no end-of-packet and gives no disable strobe.
- R2: `eof1_mark` is high for exactly the one cycle after a rising clock edge at which `bit_en`, `locked` and `frame_cnt == EOF1_BEFORE + SOF_LAG` are all true. `eof2_mark` behaves the same way at `frame_cnt == EOF2_BEFORE + SOF_LAG`. A count held across cycles with `bit_en` low never produces a mark.
- R3: If any bit of `conn_req` is set at the first-point edge, `eop_drive` rises in the next cycle.
- R4: With `EOP_ON_IDLE = 1` the end-of-packet starts at every first-point edge. With `EOP_ON_IDLE = 0` it starts only as described in R3.
- R5: Once started, `eop_drive` stays high until `EOP_BITS` further `bit_en` edges have passed, which is `EOP_BITS` bit times, and then falls. It is low at the second point.
- R6: Bit i of `babble_dis` is high for exactly one cycle after the second-point edge, and only if bit i of `conn_req` is 1 at that edge. At all other times it is 0.
- R7: After reset, `conn_inhibit` is 1, and `eop_drive`, `babble_dis` and both marks are 0.
- R8: A `resume_evt` at an edge sets `conn_inhibit` from the next cycle. This holds even when `locked` rises at that same edge.
- R9: Without a resume, `conn_inhibit` clears in the cycle after an edge where `locked` is 1 and was 0 at the previous edge. Holding `locked` high does not clear it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle qualifier, once per full-speed bit time |
| frame_cnt | input | CNT_W | Frame timer value, counting down toward zero at frame end |
| locked | input | 1 | Frame timer is synchronized to start-of-frame |
| resume_evt | input | 1 | Pulse when the hub resumes |
| conn_req | input | N_PORTS | Per downstream port: holds upstream connectivity |
| eop_drive | output | 1 | Request to drive end-of-packet on the upstream port |
| babble_dis | output | N_PORTS | Per-port one-cycle babbler disable strobe |
| conn_inhibit | output | 1 | Block all downstream connectivity |
| eof1_mark | output | 1 | One-cycle mark of the first end-of-frame point |
| eof2_mark | output | 1 | One-cycle mark of the second end-of-frame point |

## Verification
Two functions can act in the same cycle. The first is the inhibit flag, which a resume sets and a fresh lock clears. The second is the end-of-frame guard, which produces the marks, the end-of-packet and the disable strobes. The bench raises a resume pulse on the exact edge that decodes the second point. It then checks that the disable strobe follows the requested ports while the inhibit flag is set, each independent of the other. It also raises a resume in the same edge where `locked` goes high and checks that the flag stays set. Only a later lock transition with no resume clears it.

// File: rtl/hub_eof_pkg.sv
package hub_eof_pkg;

   // Worst-case frame skew a hub must tolerate across two missed frames.
   localparam int unsigned SKEW_BITS = 9;

   // Timer value at which a point placed a given number of bit times
   // before the frame end is reached, given the start-of-frame lag.
   function automatic int unsigned guard_count(input int unsigned before_end,
                                               input int unsigned sof_lag);
      return before_end + sof_lag;
   endfunction

endpackage

// File: rtl/eof_point_detect.sv
module eof_point_detect #(
   parameter int unsigned CNT_W = 14,
   parameter int unsigned MATCH = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             locked,
   input  logic [CNT_W-1:0] frame_cnt,
   output logic             hit_now,
   output logic             mark
);
   localparam logic [CNT_W-1:0] MATCH_V = CNT_W'(MATCH);

   assign hit_now = bit_en && locked && (frame_cnt == MATCH_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mark <= 1'b0;
      else        mark <= hit_now;
   end
endmodule

// File: rtl/eop_driver.sv
module eop_driver #(
   parameter int unsigned EOP_BITS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic start,
   output logic eop_drive
);
   localparam int unsigned LW = $clog2(EOP_BITS + 1);

   logic [LW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         left <= '0;
      else if (start)                     left <= LW'(EOP_BITS);
      else if (bit_en && (left != '0))    left <= left - LW'(1);
   end

   assign eop_drive = (left != '0);
endmodule

// File: rtl/babble_strobe.sv
module babble_strobe #(
   parameter int unsigned N_PORTS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_now,
   input  logic [N_PORTS-1:0] conn_req,
   output logic [N_PORTS-1:0] babble_dis
);
   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) babble_dis[p] <= 1'b0;
         else        babble_dis[p] <= hit_now && conn_req[p];
      end
   end
endmodule

// File: rtl/resume_inhibit.sv
module resume_inhibit (
   input  logic clk,
   input  logic rst_n,
   input  logic locked,
   input  logic resume_evt,
   output logic conn_inhibit
);
   logic lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conn_inhibit <= 1'b1;
         lock_q       <= 1'b0;
      end else begin
         lock_q <= locked;
         if (resume_evt)              conn_inhibit <= 1'b1;
         else if (locked && !lock_q)  conn_inhibit <= 1'b0;
      end
   end
endmodule

// File: rtl/hub_eof_guard.sv
module hub_eof_guard #(
   parameter int unsigned N_PORTS     = 4,
   parameter int unsigned CNT_W       = 14,
   parameter int unsigned EOF1_BEFORE = 32,
   parameter int unsigned EOF2_BEFORE = 12,
   parameter int unsigned SOF_LAG     = 18,
   parameter int unsigned EOP_BITS    = 4,
   parameter bit          EOP_ON_IDLE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_en,
   input  logic [CNT_W-1:0]   frame_cnt,
   input  logic               locked,
   input  logic               resume_evt,
   input  logic [N_PORTS-1:0] conn_req,
   output logic               eop_drive,
   output logic [N_PORTS-1:0] babble_dis,
   output logic               conn_inhibit,
   output logic               eof1_mark,
   output logic               eof2_mark
);
   import hub_eof_pkg::*;

   localparam int unsigned EOF1_CNT = guard_count(EOF1_BEFORE, SOF_LAG);
   localparam int unsigned EOF2_CNT = guard_count(EOF2_BEFORE, SOF_LAG);

   // Elaboration-time parameter checks
   if (N_PORTS < 1) begin : g_bad_ports
      $error("hub_eof_guard: N_PORTS must be at least 1");
   end
   if (CNT_W < 2 || CNT_W > 30) begin : g_bad_width
      $error("hub_eof_guard: CNT_W out of range");
   end
   if (EOF1_CNT >= (32'd1 << CNT_W)) begin : g_bad_range
      $error("hub_eof_guard: first point does not fit the timer width");
   end
   if (EOF1_BEFORE < EOF2_BEFORE + SKEW_BITS + EOP_BITS) begin : g_bad_gap
      $error("hub_eof_guard: gap between points too small for EOP plus skew");
   end
   if (EOF2_BEFORE < SKEW_BITS + 1) begin : g_bad_eof2
      $error("hub_eof_guard: second point too close to frame end");
   end
   if (EOP_BITS < 1) begin : g_bad_eop
      $error("hub_eof_guard: EOP_BITS must be at least 1");
   end

   logic hit1, hit2, eop_start;

   eof_point_detect #(.CNT_W(CNT_W), .MATCH(EOF1_CNT)) u_pt1 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .locked(locked),
      .frame_cnt(frame_cnt), .hit_now(hit1), .mark(eof1_mark));

   eof_point_detect #(.CNT_W(CNT_W), .MATCH(EOF2_CNT)) u_pt2 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .locked(locked),
      .frame_cnt(frame_cnt), .hit_now(hit2), .mark(eof2_mark));

   // Variant: EOP on every first point, or only when a port holds the path
   if (EOP_ON_IDLE) begin : g_eop_always
      logic [N_PORTS-1:0] req_unused;
      assign req_unused = conn_req;
      assign eop_start  = hit1;
   end else begin : g_eop_on_conn
      assign eop_start = hit1 && (|conn_req);
   end

   eop_driver #(.EOP_BITS(EOP_BITS)) u_eop (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(eop_start),
      .eop_drive(eop_drive));

   babble_strobe #(.N_PORTS(N_PORTS)) u_bab (
      .clk(clk), .rst_n(rst_n), .hit_now(hit2), .conn_req(conn_req),
      .babble_dis(babble_dis));

   resume_inhibit u_inh (
      .clk(clk), .rst_n(rst_n), .locked(locked), .resume_evt(resume_evt),
      .conn_inhibit(conn_inhibit));
endmodule

module hub_eof_guard_chk #(
   parameter int unsigned N_PORTS     = 4,
   parameter int unsigned CNT_W       = 14,
   parameter int unsigned EOF1_BEFORE = 32,
   parameter int unsigned EOF2_BEFORE = 12,
   parameter int unsigned SOF_LAG     = 18,
   parameter bit          EOP_ON_IDLE = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bit_en,
   input logic [CNT_W-1:0]   frame_cnt,
   input logic               locked,
   input logic               resume_evt,
   input logic [N_PORTS-1:0] conn_req,
   input logic               eop_drive,
   input logic [N_PORTS-1:0] babble_dis,
   input logic               conn_inhibit,
   input logic               eof1_mark,
   input logic               eof2_mark
);
   import hub_eof_pkg::*;
   localparam logic [CNT_W-1:0] E1 = CNT_W'(guard_count(EOF1_BEFORE, SOF_LAG));

   p_mark_needs_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (eof1_mark || eof2_mark) |-> $past(locked));

   p_marks_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(eof1_mark && eof2_mark));

   p_eop_on_conn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && locked && (frame_cnt == E1) && (|conn_req)) |=> eop_drive);

   p_eop_rise_at_eof1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eop_drive) |-> eof1_mark);

   p_eop_done_by_eof2_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eof2_mark |-> !eop_drive);

   p_strobe_with_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|babble_dis) |-> eof2_mark);

   p_strobe_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|babble_dis) |-> ((babble_dis & ~$past(conn_req)) == '0));

   p_resume_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resume_evt |=> conn_inhibit);
endmodule

bind hub_eof_guard hub_eof_guard_chk #(
   .N_PORTS(N_PORTS), .CNT_W(CNT_W), .EOF1_BEFORE(EOF1_BEFORE),
   .EOF2_BEFORE(EOF2_BEFORE), .SOF_LAG(SOF_LAG), .EOP_ON_IDLE(EOP_ON_IDLE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_cnt(frame_cnt),
   .locked(locked), .resume_evt(resume_evt), .conn_req(conn_req),
   .eop_drive(eop_drive), .babble_dis(babble_dis), .conn_inhibit(conn_inhibit),
   .eof1_mark(eof1_mark), .eof2_mark(eof2_mark));

// File: tb/test_hub_eof_guard.sv
module test_hub_eof_guard;
   localparam int NP = 3;
   localparam int CW = 7;
   localparam int B1 = 32;
   localparam int B2 = 12;
   localparam int LAG = 18;
   localparam int EB = 4;
   localparam int E1 = B1 + LAG;   // 50
   localparam int E2 = B2 + LAG;   // 30
   localparam int TOP = (1 << CW) - 1;

   logic clk = 1'b0;
   always #4 clk = ~clk;           // 125 MHz

   logic          rst_n = 1'b0, bit_en = 1'b0, locked = 1'b0, resume_evt = 1'b0;
   logic [CW-1:0] frame_cnt = '0;
   logic [NP-1:0] conn_req = '0;

   logic          eop_a, inh_a, m1_a, m2_a;
   logic [NP-1:0] bab_a;
   logic          eop_b, inh_b, m1_b, m2_b;
   logic [NP-1:0] bab_b;

   hub_eof_guard #(.N_PORTS(NP), .CNT_W(CW), .EOF1_BEFORE(B1), .EOF2_BEFORE(B2),
                   .SOF_LAG(LAG), .EOP_BITS(EB), .EOP_ON_IDLE(1'b0)) i_hub_eof_guard (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_cnt(frame_cnt),
      .locked(locked), .resume_evt(resume_evt), .conn_req(conn_req),
      .eop_drive(eop_a), .babble_dis(bab_a), .conn_inhibit(inh_a),
      .eof1_mark(m1_a), .eof2_mark(m2_a));

   hub_eof_guard #(.N_PORTS(NP), .CNT_W(CW), .EOF1_BEFORE(B1), .EOF2_BEFORE(B2),
                   .SOF_LAG(LAG), .EOP_BITS(EB), .EOP_ON_IDLE(1'b1)) i_hub_eof_guard_idle (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_cnt(frame_cnt),
      .locked(locked), .resume_evt(resume_evt), .conn_req(conn_req),
      .eop_drive(eop_b), .babble_dis(bab_b), .conn_inhibit(inh_b),
      .eof1_mark(m1_b), .eof2_mark(m2_b));

   int vectors = 0, errors = 0;
   bit done = 1'b0;

   // Bench expectations
   int            left_a = 0, left_b = 0;
   logic          inh_m = 1'b1, lkp_m = 1'b0, x1 = 1'b0, x2 = 1'b0;
   logic [NP-1:0] xbab = '0;
   string         t_mark, t_eop, t_bab, t_inh;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (cnt=%0d)", tag, act, exp, frame_cnt);
      end
   endtask

   // Inputs are set at a falling edge; this samples one rising edge.
   task automatic step();
      logic h1, h2;
      @(posedge clk);
      h1 = bit_en && locked && (int'(frame_cnt) == E1);
      h2 = bit_en && locked && (int'(frame_cnt) == E2);
      t_mark = locked ? "R2" : "R1";
      t_bab  = locked ? "R6" : "R1";
      t_inh  = resume_evt ? "R8" : "R9";
      if (!rst_n) begin
         left_a = 0; left_b = 0; inh_m = 1'b1; lkp_m = 1'b0;
         x1 = 1'b0; x2 = 1'b0; xbab = '0;
         t_mark = "R7"; t_bab = "R7"; t_inh = "R7";
      end else begin
         x1 = h1; x2 = h2;
         xbab = h2 ? conn_req : '0;
         if (h1 && (|conn_req))          left_a = EB;
         else if (bit_en && left_a > 0)  left_a--;
         if (h1)                         left_b = EB;
         else if (bit_en && left_b > 0)  left_b--;
         if (resume_evt)                 inh_m = 1'b1;
         else if (locked && !lkp_m)      inh_m = 1'b0;
         lkp_m = locked;
      end
      @(negedge clk);
      t_eop = (left_a > 0) ? "R3" : "R5";
      check(t_mark, 32'(m1_a), 32'(x1));
      check(t_mark, 32'(m2_a), 32'(x2));
      check(t_eop,  32'(eop_a), 32'(left_a > 0));
      check("R4",   32'(eop_b), 32'(left_b > 0));
      check(t_bab,  32'(bab_a), 32'(xbab));
      check(t_bab,  32'(bab_b), 32'(xbab));
      check(t_inh,  32'(inh_a), 32'(inh_m));
      check(t_inh,  32'(inh_b), 32'(inh_m));
   endtask

   // One frame: counter from TOP down to 0, two clocks per bit time.
   // p1 is held around the first point, p2 around the second point.
   task automatic run_frame(input logic [NP-1:0] p1, input logic [NP-1:0] p2,
                            input logic lk, input int res_bit);
      for (int b = TOP; b >= 0; b--) begin
         frame_cnt  = CW'(b);
         conn_req   = (b > (E1 + E2) / 2) ? p1 : p2;
         locked     = lk;
         bit_en     = 1'b1;
         resume_evt = (b == res_bit);
         step();
         bit_en     = 1'b0;
         resume_evt = 1'b0;
         step();
      end
   endtask

   initial begin
      @(negedge clk);
      // R7: reset state
      for (int i = 0; i < 3; i++) step();
      rst_n = 1'b1;
      // R1: unlocked frames with every port requesting
      run_frame('1, '1, 1'b0, -1);
      run_frame('1, '0, 1'b0, -1);
      // R2..R6, R9: locked sweep over all request pairs at both points
      for (int p1 = 0; p1 < (1 << NP); p1++)
         for (int p2 = 0; p2 < (1 << NP); p2++)
            run_frame(NP'(p1), NP'(p2), 1'b1, -1);
      // R8 with R6: resume on the very edge of the second point
      run_frame(3'b101, 3'b011, 1'b1, E2);
      // Lock still high: inhibit must stay set through a whole frame (R9)
      run_frame(3'b111, 3'b110, 1'b1, -1);
      // Drop lock, then resume on the same edge that lock returns (R8)
      run_frame(3'b001, 3'b001, 1'b0, -1);
      run_frame(3'b010, 3'b100, 1'b1, TOP);
      // Fresh lock transition without resume clears the inhibit (R9)
      run_frame(3'b000, 3'b000, 1'b0, -1);
      run_frame(3'b100, 3'b010, 1'b1, -1);
      // Reset again in mid-frame: outputs return to idle (R7)
      frame_cnt = CW'(E1); conn_req = '1; locked = 1'b1; bit_en = 1'b1;
      rst_n = 1'b0;
      step();
      bit_en = 1'b0;
      step();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule